// File: doc/BRIEF.md
# Shared-Buffer Cell Forwarding Dispatcher

This block is the forwarding core of a chip that sits in a chain of identical chips, each acting as a three-way cell switch. The cells are fixed-size, 53 bytes by default. They come from either neighbour or from the local transmit path and arrive on one merged byte stream. Each cell is written into a free slot of a shared cell buffer. At the same time its circuit identifier, a path number in byte 0 and a 16-bit channel number in bytes 1 and 2, is captured for a lookup in a small associative circuit table.

When the whole cell has been stored, the table entry decides its fate:
- It can be delivered to the local device.
- It can be passed on toward the next chip.
- It can go both ways at once.
- It can be discarded, which increments a miss counter.

Only a slot number is queued. Each of the two outputs has a normal queue and a low-latency bypass queue, and a per-circuit flag picks between them. One dispatcher per output takes a slot number when its consumer signals ready. It streams the 53 bytes out of the shared buffer. A slot returns to the free pool only once every output it was queued for has finished reading it.

Top module: `cell_fwd_dispatch`

## Requirements
- R1: While reset is held and right after it is released, neither output is valid and the miss counter is zero.
- R2: A cell whose path number (byte 0) and channel number (byte 1 high, byte 2 low) match a valid table entry whose forward flag is set leaves on the forward output. It carries all its bytes unchanged, with sop on byte 0 and eop on byte 52.
- R3: A cell matching an entry whose local flag is set leaves on the local output, unchanged.
- R4: A cell matching an entry with both flags set leaves on both outputs.
- R5: A cell that matches no valid entry, or matches an entry with neither flag set, appears on no output and raises the miss counter by exactly one.
- R6: When a dispatcher chooses its next cell, any cell waiting in its low-latency queue (entry flag set) goes before every cell waiting in its normal queue.
- R7: Within one queue, cells leave in arrival order.
- R8: A slot stays occupied until all its outputs have read it. An arriving cell that finds all slots occupied is dropped silently, without counting a miss. Once slots drain they are reused.
- R9: An output stream starts only with sop and then presents one byte every cycle through eop, whatever its ready input does after the cell has started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Arrival byte valid |
| in_sop | input | 1 | Arrival byte is byte 0 of a cell |
| in_byte | input | 8 | Arrival byte |
| cfg_we | input | 1 | Write one table entry |
| cfg_idx | input | $clog2(N_VC) | Table entry index |
| cfg_valid | input | 1 | Entry is in use |
| cfg_vpi | input | 8 | Entry path number |
| cfg_vci | input | 16 | Entry channel number |
| cfg_to_loc | input | 1 | Entry delivers to the local device |
| cfg_to_fwd | input | 1 | Entry forwards to the next chip |
| cfg_lowlat | input | 1 | Entry uses the low-latency queues |
| fwd_ready | input | 1 | Forward consumer can take a new cell |
| fwd_valid | output | 1 | Forward byte valid |
| fwd_sop | output | 1 | Forward byte 0 |
| fwd_eop | output | 1 | Forward last byte |
| fwd_byte | output | 8 | Forward byte |
| loc_ready | input | 1 | Local consumer can take a new cell |
| loc_valid | output | 1 | Local byte valid |
| loc_sop | output | 1 | Local byte 0 |
| loc_eop | output | 1 | Local last byte |
| loc_byte | output | 8 | Local byte |
| miss_count | output | MISS_W | Count of cells discarded by lookup |

## Verification
The bench holds a consumer's ready low so that cells pile up. It then checks that a low-latency cell queued last still leaves first. A design that ignored the flag would return arrival order. A multipoint cell is read by the forward side while the local side is stalled, and three more local cells then fill the buffer. A design that freed the slot after the first reader would accept a fourth cell and corrupt or duplicate the stalled multipoint cell. Near-miss identifiers, entries that are invalid, and entries with no destination must all be counted as misses without emitting anything. A buffer-full drop must not be counted as a miss. Dropping ready in the middle of a cell must not cut the cell short.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  localparam int VPI_W = 8;
  localparam int VCI_W = 16;

  typedef struct packed {
    logic             valid;
    logic [VPI_W-1:0] vpi;
    logic [VCI_W-1:0] vci;
    logic             to_loc;
    logic             to_fwd;
    logic             lowlat;
  } vc_entry_t;

  // An entry counts as a hit only when it is live, matches, and has a destination.
  function automatic logic entry_hit(vc_entry_t e, logic [VPI_W-1:0] vpi,
                                     logic [VCI_W-1:0] vci);
    return e.valid && (e.to_loc || e.to_fwd) && (e.vpi == vpi) && (e.vci == vci);
  endfunction
endpackage

// File: rtl/cfd_vc_table.sv
module cfd_vc_table
  import cfd_pkg::*;
#(
  parameter int N_VC = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [$clog2(N_VC)-1:0] cfg_idx,
  input  vc_entry_t               cfg_entry,
  input  logic [VPI_W-1:0]        key_vpi,
  input  logic [VCI_W-1:0]        key_vci,
  output logic                    hit,
  output vc_entry_t               hit_entry
);
  vc_entry_t       tbl [N_VC];
  logic [N_VC-1:0] match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_VC; i++) tbl[i] <= '0;
    end else if (cfg_we) begin
      tbl[cfg_idx] <= cfg_entry;
    end
  end

  for (genvar g = 0; g < N_VC; g++) begin : g_match
    assign match[g] = entry_hit(tbl[g], key_vpi, key_vci);
  end

  // Lowest matching index wins.
  always_comb begin
    hit       = |match;
    hit_entry = '0;
    for (int i = N_VC - 1; i >= 0; i--) begin
      if (match[i]) hit_entry = tbl[i];
    end
  end
endmodule

// File: rtl/cfd_desc_fifo.sv
module cfd_desc_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic            pop,
  output logic [W-1:0]    dout,
  output logic            nempty,
  output logic [CNTW-1:0] count
);
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CNTW'(push) - CNTW'(pop);
    end
  end

  assign dout   = store[rd_ptr];
  assign nempty = (count != '0);
endmodule

// File: rtl/cfd_slot_alloc.sv
module cfd_slot_alloc #(
  parameter int N_SLOTS = 4,
  parameter int SW      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_en,
  output logic               alloc_ok,
  output logic [SW-1:0]      alloc_slot,
  input  logic               rel_en,
  input  logic [SW-1:0]      rel_slot,
  input  logic [1:0]         pend_set,      // [1] forward, [0] local
  input  logic               loc_done,
  input  logic [SW-1:0]      loc_done_slot,
  input  logic               fwd_done,
  input  logic [SW-1:0]      fwd_done_slot,
  output logic [N_SLOTS-1:0] busy
);
  logic [N_SLOTS-1:0] held, pend_l, pend_f;

  assign busy = held | pend_l | pend_f;

  always_comb begin
    alloc_ok   = 1'b0;
    alloc_slot = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        alloc_ok   = 1'b1;
        alloc_slot = SW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held   <= '0;
      pend_l <= '0;
      pend_f <= '0;
    end else begin
      for (int s = 0; s < N_SLOTS; s++) begin
        if (alloc_en && alloc_ok && alloc_slot == SW'(s)) held[s] <= 1'b1;
        else if (rel_en && rel_slot == SW'(s))             held[s] <= 1'b0;
        if (rel_en && rel_slot == SW'(s) && pend_set[0])    pend_l[s] <= 1'b1;
        else if (loc_done && loc_done_slot == SW'(s))       pend_l[s] <= 1'b0;
        if (rel_en && rel_slot == SW'(s) && pend_set[1])    pend_f[s] <= 1'b1;
        else if (fwd_done && fwd_done_slot == SW'(s))       pend_f[s] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfd_dispatch.sv
module cfd_dispatch #(
  parameter int CELL_BYTES = 53,
  parameter int SW         = 2,
  parameter int CW         = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready,
  input  logic          ll_nempty,
  input  logic [SW-1:0] ll_slot,
  input  logic          nm_nempty,
  input  logic [SW-1:0] nm_slot,
  output logic          start,
  output logic          pop_ll,
  output logic          pop_nm,
  output logic          active,
  output logic [SW-1:0] slot,
  output logic [CW-1:0] idx,
  output logic          sop,
  output logic          eop
);
  localparam logic [CW-1:0] LAST = CW'(CELL_BYTES - 1);

  assign start  = !active && ready && (ll_nempty || nm_nempty);
  assign pop_ll = start && ll_nempty;
  assign pop_nm = start && !ll_nempty;
  assign sop    = active && (idx == '0);
  assign eop    = active && (idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      slot   <= '0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
      slot   <= ll_nempty ? ll_slot : nm_slot;
    end else if (active) begin
      if (idx == LAST) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cell_fwd_dispatch.sv
module cell_fwd_dispatch
  import cfd_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int N_SLOTS    = 4,
  parameter int N_VC       = 8,
  parameter int MISS_W     = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sop,
  input  logic [7:0]              in_byte,
  input  logic                    cfg_we,
  input  logic [$clog2(N_VC)-1:0] cfg_idx,
  input  logic                    cfg_valid,
  input  logic [7:0]              cfg_vpi,
  input  logic [15:0]             cfg_vci,
  input  logic                    cfg_to_loc,
  input  logic                    cfg_to_fwd,
  input  logic                    cfg_lowlat,
  input  logic                    fwd_ready,
  output logic                    fwd_valid,
  output logic                    fwd_sop,
  output logic                    fwd_eop,
  output logic [7:0]              fwd_byte,
  input  logic                    loc_ready,
  output logic                    loc_valid,
  output logic                    loc_sop,
  output logic                    loc_eop,
  output logic [7:0]              loc_byte,
  output logic [MISS_W-1:0]       miss_count
);
  localparam int SW   = $clog2(N_SLOTS);
  localparam int CW   = $clog2(CELL_BYTES);
  localparam int AW   = $clog2(N_SLOTS * CELL_BYTES);
  localparam int CNTW = $clog2(N_SLOTS + 1);

  function automatic logic [AW-1:0] cell_addr(logic [SW-1:0] s, logic [CW-1:0] i);
    return AW'(int'(s) * CELL_BYTES + int'(i));
  endfunction

  logic [7:0] cell_mem [N_SLOTS*CELL_BYTES];

  // ingress state
  logic          wr_on;
  logic [SW-1:0] wr_slot;
  logic [CW-1:0] wr_idx;
  logic [7:0]    hdr_vpi;
  logic [15:0]   hdr_vci;

  // named internal events
  logic sop_evt, body_evt, commit_evt, abort_evt, miss_evt;
  logic alloc_ok;
  logic [SW-1:0] alloc_slot;
  logic [N_SLOTS-1:0] slot_busy;
  logic lk_hit;
  vc_entry_t lk_entry, cfg_entry;
  logic go_loc, go_fwd;

  // queue index q = out*2 + lowlat; out 0 = local, 1 = forward
  logic [3:0]           q_push, q_pop, q_nempty;
  logic [3:0][SW-1:0]   q_head;
  logic [3:0][CNTW-1:0] q_cnt;
  logic [1:0]           d_start, d_active, d_sop, d_eop, d_ready;
  logic [1:0][SW-1:0]   d_slot;
  logic [1:0][CW-1:0]   d_idx;

  assign sop_evt    = in_valid && in_sop;
  assign abort_evt  = sop_evt && wr_on;
  assign body_evt   = in_valid && !in_sop && wr_on;
  assign commit_evt = body_evt && (wr_idx == CW'(CELL_BYTES - 1));
  assign miss_evt   = commit_evt && !lk_hit;
  assign go_loc     = commit_evt && lk_hit && lk_entry.to_loc;
  assign go_fwd     = commit_evt && lk_hit && lk_entry.to_fwd;

  assign cfg_entry = '{valid: cfg_valid, vpi: cfg_vpi, vci: cfg_vci,
                       to_loc: cfg_to_loc, to_fwd: cfg_to_fwd, lowlat: cfg_lowlat};

  cfd_vc_table #(.N_VC(N_VC)) u_table (
    .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_entry,
    .key_vpi(hdr_vpi), .key_vci(hdr_vci), .hit(lk_hit), .hit_entry(lk_entry)
  );

  cfd_slot_alloc #(.N_SLOTS(N_SLOTS), .SW(SW)) u_alloc (
    .clk, .rst_n,
    .alloc_en(sop_evt), .alloc_ok, .alloc_slot,
    .rel_en(commit_evt || abort_evt), .rel_slot(wr_slot),
    .pend_set(commit_evt ? {go_fwd, go_loc} : 2'b00),
    .loc_done(d_eop[0]), .loc_done_slot(d_slot[0]),
    .fwd_done(d_eop[1]), .fwd_done_slot(d_slot[1]),
    .busy(slot_busy)
  );

  always_ff @(posedge clk) begin
    if (sop_evt && alloc_ok) cell_mem[cell_addr(alloc_slot, '0)] <= in_byte;
    else if (body_evt)       cell_mem[cell_addr(wr_slot, wr_idx)] <= in_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_on      <= 1'b0;
      wr_slot    <= '0;
      wr_idx     <= '0;
      hdr_vpi    <= '0;
      hdr_vci    <= '0;
      miss_count <= '0;
    end else begin
      if (sop_evt) begin
        wr_on   <= alloc_ok;
        wr_slot <= alloc_slot;
        wr_idx  <= CW'(1);
        hdr_vpi <= in_byte;
      end else if (body_evt) begin
        if (commit_evt) wr_on <= 1'b0;
        wr_idx <= wr_idx + 1'b1;
        if (wr_idx == CW'(1)) hdr_vci[15:8] <= in_byte;
        if (wr_idx == CW'(2)) hdr_vci[7:0]  <= in_byte;
      end
      if (miss_evt) miss_count <= miss_count + 1'b1;
    end
  end

  assign q_push[0] = go_loc && !lk_entry.lowlat;
  assign q_push[1] = go_loc &&  lk_entry.lowlat;
  assign q_push[2] = go_fwd && !lk_entry.lowlat;
  assign q_push[3] = go_fwd &&  lk_entry.lowlat;

  for (genvar q = 0; q < 4; q++) begin : g_queue
    cfd_desc_fifo #(.DEPTH(N_SLOTS), .W(SW)) u_q (
      .clk, .rst_n, .push(q_push[q]), .din(wr_slot), .pop(q_pop[q]),
      .dout(q_head[q]), .nempty(q_nempty[q]), .count(q_cnt[q])
    );
  end

  assign d_ready = {fwd_ready, loc_ready};

  for (genvar o = 0; o < 2; o++) begin : g_out
    cfd_dispatch #(.CELL_BYTES(CELL_BYTES), .SW(SW), .CW(CW)) u_disp (
      .clk, .rst_n, .ready(d_ready[o]),
      .ll_nempty(q_nempty[2*o+1]), .ll_slot(q_head[2*o+1]),
      .nm_nempty(q_nempty[2*o]),   .nm_slot(q_head[2*o]),
      .start(d_start[o]), .pop_ll(q_pop[2*o+1]), .pop_nm(q_pop[2*o]),
      .active(d_active[o]), .slot(d_slot[o]), .idx(d_idx[o]),
      .sop(d_sop[o]), .eop(d_eop[o])
    );
  end

  assign loc_valid = d_active[0];
  assign loc_sop   = d_sop[0];
  assign loc_eop   = d_eop[0];
  assign loc_byte  = cell_mem[cell_addr(d_slot[0], d_idx[0])];
  assign fwd_valid = d_active[1];
  assign fwd_sop   = d_sop[1];
  assign fwd_eop   = d_eop[1];
  assign fwd_byte  = cell_mem[cell_addr(d_slot[1], d_idx[1])];
endmodule

// File: rtl/cfd_checker.sv
module cfd_checker #(
  parameter int N_SLOTS = 4,
  parameter int MISS_W  = 16,
  localparam int SW     = $clog2(N_SLOTS),
  localparam int CNTW   = $clog2(N_SLOTS + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 loc_valid,
  input logic                 loc_sop,
  input logic                 loc_eop,
  input logic                 fwd_valid,
  input logic                 fwd_sop,
  input logic                 fwd_eop,
  input logic [N_SLOTS-1:0]   slot_busy,
  input logic [1:0][SW-1:0]   d_slot,
  input logic [1:0]           d_start,
  input logic [3:0]           q_nempty,
  input logic [3:0]           q_push,
  input logic [3:0][CNTW-1:0] q_cnt,
  input logic                 miss_evt,
  input logic [MISS_W-1:0]    miss_count
);
  a_r9_fwd_rise_sop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_valid) |-> fwd_sop);
  a_r9_loc_rise_sop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loc_valid) |-> loc_sop);
  a_r9_fwd_fall_eop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fwd_valid) |-> $past(fwd_eop));
  a_r9_loc_fall_eop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loc_valid) |-> $past(loc_eop));

  a_r8_loc_reads_held: assert property (@(posedge clk) disable iff (!rst_n)
    loc_valid |-> slot_busy[d_slot[0]]);
  a_r8_fwd_reads_held: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> slot_busy[d_slot[1]]);
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt[0] <= CNTW'(N_SLOTS)) && (q_cnt[1] <= CNTW'(N_SLOTS)) &&
    (q_cnt[2] <= CNTW'(N_SLOTS)) && (q_cnt[3] <= CNTW'(N_SLOTS)));

  a_r6_loc_ll_first: assert property (@(posedge clk) disable iff (!rst_n)
    d_start[0] && q_nempty[1] && !q_push[1] |=> q_cnt[1] + 1'b1 == $past(q_cnt[1]));
  a_r6_fwd_ll_first: assert property (@(posedge clk) disable iff (!rst_n)
    d_start[1] && q_nempty[3] && !q_push[3] |=> q_cnt[3] + 1'b1 == $past(q_cnt[3]));

  a_r5_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count != $past(miss_count)) |-> ($past(miss_evt) && miss_count == $past(miss_count) + 1'b1));
  a_r5_miss_counted: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> miss_count != $past(miss_count));
endmodule

bind cell_fwd_dispatch cfd_checker #(.N_SLOTS(N_SLOTS), .MISS_W(MISS_W)) u_chk (.*);

// File: tb/cell_fwd_dispatch_test.sv
`timescale 1ns/1ps
module cell_fwd_dispatch_test;
  localparam int CB = 53;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0;
  logic [7:0] in_byte = 0;
  logic cfg_we = 0, cfg_valid = 0, cfg_to_loc = 0, cfg_to_fwd = 0, cfg_lowlat = 0;
  logic [2:0] cfg_idx = 0;
  logic [7:0] cfg_vpi = 0;
  logic [15:0] cfg_vci = 0;
  logic fwd_ready = 1, loc_ready = 1;
  logic fwd_valid, fwd_sop, fwd_eop, loc_valid, loc_sop, loc_eop;
  logic [7:0] fwd_byte, loc_byte;
  logic [15:0] miss_count;

  int vectors = 0, miscompares = 0, r9_err = 0, cyc = 0;

  always #2 clk = ~clk;

  cell_fwd_dispatch uut (.*);

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog: got %0d cycles exp fewer", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %0d exp %0d", req, got, exp);
    end
  endtask

  // payload byte i (i >= 5) is tag + i; returns -1 if inconsistent
  function automatic int tag_of(input logic [7:0] b [CB]);
    int t = int'(b[5]) - 5;
    for (int i = 5; i < CB; i++) if (b[i] != 8'(t + i)) return -1;
    return t;
  endfunction

  logic [7:0] fbuf [CB], lbuf [CB];
  int fpos = 0, lpos = 0, fn = 0, ln = 0;
  bit fon = 0, lon = 0;
  int ftag [64], ltag [64];
  logic [7:0] fvpi [64], lvpi [64];

  always @(negedge clk) if (rst_n) begin
    if (fwd_valid) begin
      if (fwd_sop) begin if (fon) r9_err++; fon = 1; fpos = 0; end
      else if (!fon) r9_err++;
      if (fpos < CB) fbuf[fpos] = fwd_byte;
      fpos++;
      if (fwd_eop) begin
        if (fpos != CB) r9_err++;
        ftag[fn] = tag_of(fbuf); fvpi[fn] = fbuf[0]; fn++; fon = 0;
      end
    end else if (fon) begin r9_err++; fon = 0; end
    if (loc_valid) begin
      if (loc_sop) begin if (lon) r9_err++; lon = 1; lpos = 0; end
      else if (!lon) r9_err++;
      if (lpos < CB) lbuf[lpos] = loc_byte;
      lpos++;
      if (loc_eop) begin
        if (lpos != CB) r9_err++;
        ltag[ln] = tag_of(lbuf); lvpi[ln] = lbuf[0]; ln++; lon = 0;
      end
    end else if (lon) begin r9_err++; lon = 0; end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_entry(input int idx, input bit v, input [7:0] vpi, input [15:0] vci,
                           input bit l, input bit f, input bit ll);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_valid = v; cfg_vpi = vpi; cfg_vci = vci;
    cfg_to_loc = l; cfg_to_fwd = f; cfg_lowlat = ll;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send_cell(input [7:0] vpi, input [15:0] vci, input [7:0] tag);
    for (int i = 0; i < CB; i++) begin
      @(negedge clk);
      in_valid = 1; in_sop = (i == 0);
      in_byte = (i == 0) ? vpi : (i == 1) ? vci[15:8] : (i == 2) ? vci[7:0] :
                (i < 5) ? 8'h00 : 8'(tag + i);
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0;
  endtask

  task automatic t_reset();
    chk(!fwd_valid && !loc_valid, "R1 outputs idle in reset", int'(fwd_valid | loc_valid), 0);
    chk(miss_count == 0, "R1 miss count in reset", int'(miss_count), 0);
    @(negedge clk); rst_n = 1;
    wait_cycles(2);
    chk(!fwd_valid && !loc_valid, "R1 outputs idle after reset", int'(fwd_valid | loc_valid), 0);
    chk(miss_count == 0, "R1 miss count after reset", int'(miss_count), 0);
  endtask

  task automatic t_forward();
    int f0 = fn, l0 = ln;
    send_cell(8'd1, 16'h0100, 8'd10);
    for (int i = 0; i < 10 && !fwd_valid; i++) @(negedge clk);
    fwd_ready = 0;                       // R9: drop ready mid-cell
    wait_cycles(70);
    chk(fn == f0 + 1, "R2 forward cell count", fn - f0, 1);
    chk(ftag[f0] == 10 && fvpi[f0] == 1, "R2 forward cell content", ftag[f0], 10);
    chk(ln == l0, "R2 nothing on local", ln - l0, 0);
    chk(r9_err == 0, "R9 whole cell after ready drop", r9_err, 0);
    fwd_ready = 1;
  endtask

  task automatic t_local();
    int f0 = fn, l0 = ln;
    send_cell(8'd1, 16'h0200, 8'd20);
    send_cell(8'd3, 16'h0400, 8'd21);
    wait_cycles(70);
    chk(ln == l0 + 2, "R3 local cell count", ln - l0, 2);
    chk(ltag[l0] == 20 && ltag[l0+1] == 21, "R3 local cell content", ltag[l0], 20);
    chk(fn == f0, "R3 nothing on forward", fn - f0, 0);
  endtask

  task automatic t_multi();
    int f0 = fn, l0 = ln;
    send_cell(8'd2, 16'h0300, 8'd30);
    wait_cycles(70);
    chk(fn == f0 + 1 && ftag[f0] == 30, "R4 multipoint forward copy", ftag[f0], 30);
    chk(ln == l0 + 1 && ltag[l0] == 30, "R4 multipoint local copy", ltag[l0], 30);
  endtask

  task automatic t_miss();
    int f0 = fn, l0 = ln, m0 = int'(miss_count);
    send_cell(8'd9, 16'h0100, 8'd31);    // unknown path
    send_cell(8'd1, 16'h0102, 8'd32);    // near-miss channel
    send_cell(8'd5, 16'h0600, 8'd33);    // entry not valid
    send_cell(8'd4, 16'h0500, 8'd34);    // entry without destination
    wait_cycles(70);
    chk(int'(miss_count) == m0 + 4, "R5 miss count", int'(miss_count), m0 + 4);
    chk(fn == f0 && ln == l0, "R5 misses emit nothing", fn - f0 + ln - l0, 0);
  endtask

  task automatic t_priority();
    int f0 = fn;
    fwd_ready = 0;
    send_cell(8'd1, 16'h0100, 8'd40);
    send_cell(8'd1, 16'h0100, 8'd41);
    send_cell(8'd1, 16'h0101, 8'd42);    // low-latency entry
    wait_cycles(5);
    chk(fn == f0, "R6 held while not ready", fn - f0, 0);
    fwd_ready = 1;
    wait_cycles(200);
    chk(fn == f0 + 3, "R6 all three out", fn - f0, 3);
    chk(ftag[f0] == 42, "R6 low-latency first", ftag[f0], 42);
    chk(ftag[f0+1] == 40 && ftag[f0+2] == 41, "R7 normal order", ftag[f0+1], 40);
  endtask

  task automatic t_full();
    int f0 = fn, m0 = int'(miss_count);
    fwd_ready = 0;
    for (int k = 0; k < 5; k++) send_cell(8'd1, 16'h0100, 8'(50 + k));
    fwd_ready = 1;
    wait_cycles(260);
    chk(fn == f0 + 4, "R8 fifth cell dropped", fn - f0, 4);
    for (int k = 0; k < 4; k++)
      chk(ftag[f0+k] == 50 + k, "R8 stored cells intact", ftag[f0+k], 50 + k);
    chk(int'(miss_count) == m0, "R8 drop is not a miss", int'(miss_count), m0);
    send_cell(8'd1, 16'h0100, 8'd55);
    wait_cycles(70);
    chk(fn == f0 + 5 && ftag[f0+4] == 55, "R8 slot reuse", ftag[f0+4], 55);
  endtask

  task automatic t_multi_hold();
    int f0 = fn, l0 = ln;
    loc_ready = 0;
    send_cell(8'd2, 16'h0300, 8'd60);
    wait_cycles(70);
    chk(fn == f0 + 1 && ftag[f0] == 60, "R8 forward side of held cell", ftag[f0], 60);
    for (int k = 1; k < 5; k++) send_cell(8'd1, 16'h0200, 8'(60 + k));
    loc_ready = 1;
    wait_cycles(260);
    chk(ln == l0 + 4, "R8 slot kept for second reader", ln - l0, 4);
    for (int k = 0; k < 4; k++)
      chk(ltag[l0+k] == 60 + k, "R8 local order and content", ltag[l0+k], 60 + k);
  endtask

  initial begin
    wait_cycles(5);
    t_reset();
    set_entry(0, 1, 8'd1, 16'h0100, 0, 1, 0);
    set_entry(1, 1, 8'd1, 16'h0200, 1, 0, 0);
    set_entry(2, 1, 8'd2, 16'h0300, 1, 1, 0);
    set_entry(3, 1, 8'd1, 16'h0101, 0, 1, 1);
    set_entry(4, 1, 8'd3, 16'h0400, 1, 0, 1);
    set_entry(5, 1, 8'd4, 16'h0500, 0, 0, 0);
    set_entry(6, 0, 8'd5, 16'h0600, 1, 1, 0);
    t_forward();
    t_local();
    t_multi();
    t_miss();
    t_priority();
    t_full();
    t_multi_hold();
    chk(r9_err == 0, "R9 stream framing", r9_err, 0);
    finish_run();
  end
endmodule